// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory array. A burst begins when one of two active-low address strobes captures a base address from the address bus. One strobe belongs to the processor and the other to the cache controller. After that, an active-low advance input moves a 2-bit beat counter forward. The counter changes only the two least significant bits of the address. The upper bits keep the captured base address for the whole burst.

Two beat orders are available. Linear order adds the beat count to the starting low bits modulo four. Interleaved order XORs the beat count into the starting low bits. The order is captured from a mode input at the same edge that loads the burst. The processor strobe is honoured only while the chip-select input is high. The controller strobe is honoured at any time.

Every input is sampled on the rising clock edge. The address output comes straight from registers, so it is valid one cycle after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0 and the beat count is 0. Advances given before the first load walk the low two bits through 0, 1, 2, 3.
- R2: A low `ctrl_strobe_ni` at a rising edge loads `addr_i`, whatever the value of `chip_sel_i`. From the next cycle `addr_o` equals that address.
- R3: A low `proc_strobe_ni` loads `addr_i` only when `chip_sel_i` is 1. When `chip_sel_i` is 0 the processor strobe is ignored, and `addr_o` keeps its value if nothing else acts.
- R4: A load takes priority over an advance in the same cycle. After such a cycle `addr_o` equals the new address, with the beat count at 0.
- R5: With no load, `adv_ni` = 0 steps the beat count by one. `adv_ni` = 1 holds `addr_o` unchanged.
- R6: `mode_i` = 0 at the load selects linear order: the low bits equal (start + count) mod 4. For example, a start of 1 gives 1, 2, 3, 0.
- R7: `mode_i` = 1 at the load selects interleaved order: the low bits equal start XOR count. For example, a start of 1 gives 1, 0, 3, 2.
- R8: Bits 15:2 of `addr_o` stay equal to the loaded address throughout a burst. The count wraps from 3 to 0, so the fifth beat repeats the first address.
- R9: The order is captured only at a load. Changes on `mode_i` between loads have no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Base address captured by a strobe |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, gated by chip_sel_i |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low, always honoured |
| chip_sel_i | input | 1 | Enables the processor strobe when 1 |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order captured at load: 0 linear, 1 interleaved |
| addr_o | output | 16 | Current burst word address |

## Verification
Each result is due exactly one cycle after the rising edge that samples its stimulus. This holds for a load, an advance, a hold and an ignored strobe alike, because the output is driven only by the base, order and count registers. The bench drives inputs on the falling edge and updates its model for the coming rising edge. It then compares `addr_o` on the next falling edge, so every comparison falls one full edge after the cause. Directed bursts cover both orders, the wrap, a collision between load and advance, and a gated processor strobe. A seeded random phase then mixes all inputs against the same model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned CNT_W_DEF  = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb (
  input  logic proc_strobe_ni,
  input  logic ctrl_strobe_ni,
  input  logic chip_sel_i,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_load;
  logic ctrl_load;

  assign proc_load = ~proc_strobe_ni & chip_sel_i;
  assign ctrl_load = ~ctrl_strobe_ni;

  // load wins over advance
  assign load_o = proc_load | ctrl_load;
  assign step_o = ~adv_ni & ~load_o;
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_ONE;  // wraps naturally
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] xor_low;

  assign lin_low = start_i + cnt_i;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ cnt_i[b];
  end

  assign low_o = (order_i == ORDER_INTERLEAVE) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              chip_sel_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  logic             load;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low;
  logic [ADDR_W-1:0] base_q;
  burst_order_e     order_q;

  burst_strobe_arb u_arb (
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .chip_sel_i     (chip_sel_i),
    .adv_ni         (adv_ni),
    .load_o         (load),
    .step_o         (step)
  );

  burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (step),
    .cnt_o  (cnt)
  );

  // base and order captured together at load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORDER_INTERLEAVE;
    end else if (load) begin
      base_q  <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .start_i (base_q[CNT_W-1:0]),
    .cnt_i   (cnt),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {base_q[ADDR_W-1 -: HI_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_strobe_ni,
  input logic              ctrl_strobe_ni,
  input logic              chip_sel_i,
  input logic              adv_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic             ld;
  logic             adv;
  logic             lin_q;
  logic [CNT_W-1:0] beat_q;

  assign ld  = ~ctrl_strobe_ni | (~proc_strobe_ni & chip_sel_i);
  assign adv = ~adv_ni & ~ld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q  <= 1'b0;
      beat_q <= '0;
    end else if (ld) begin
      lin_q  <= ~mode_i;
      beat_q <= '0;
    end else if (adv) begin
      beat_q <= beat_q + CNT_W'(1);
    end
  end

  p_load_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> addr_o == $past(addr_i));

  p_proc_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && !chip_sel_i && ctrl_strobe_ni && adv_ni) |=> $stable(addr_o));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_ni) |=> $stable(addr_o));

  p_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(addr_o[ADDR_W-1:CNT_W]));

  p_linear_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && lin_q) |=> addr_o[CNT_W-1:0] == $past(addr_o[CNT_W-1:0]) + CNT_W'(1));

  p_inter_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !lin_q) |=> addr_o[CNT_W-1:0] ==
      ($past(addr_o[CNT_W-1:0]) ^ $past(beat_q) ^ ($past(beat_q) + CNT_W'(1))));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .proc_strobe_ni (proc_strobe_ni),
  .ctrl_strobe_ni (ctrl_strobe_ni),
  .chip_sel_i     (chip_sel_i),
  .adv_ni         (adv_ni),
  .mode_i         (mode_i),
  .addr_o         (addr_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        proc_strobe_ni = 1'b1;
  logic        ctrl_strobe_ni = 1'b1;
  logic        chip_sel_i = 1'b0;
  logic        adv_ni = 1'b1;
  logic        mode_i = 1'b1;
  logic [15:0] addr_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  logic [15:0] m_base = '0;
  logic [1:0]  m_cnt = '0;
  bit          m_lin = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .proc_strobe_ni(proc_strobe_ni), .ctrl_strobe_ni(ctrl_strobe_ni),
    .chip_sel_i(chip_sel_i), .adv_ni(adv_ni), .mode_i(mode_i), .addr_o(addr_o)
  );

  function automatic logic [15:0] exp_addr();
    logic [1:0] lo;
    lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[15:2], lo};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // drive at negedge, update model for the coming posedge, check at next negedge
  task automatic cyc(logic c_n, logic p_n, logic cs, logic a_n, logic md,
                     logic [15:0] ad, string req);
    bit ld;
    ctrl_strobe_ni = c_n; proc_strobe_ni = p_n; chip_sel_i = cs;
    adv_ni = a_n; mode_i = md; addr_i = ad;
    ld = !c_n || (!p_n && cs);
    if (ld) begin
      m_base = ad; m_cnt = '0; m_lin = !md;
    end else if (!a_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, exp_addr());
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: addr_o=%h expected=done", addr_o);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 16'h0000);
    cyc(1,1,0,0,1,16'hFFFF,"R1");  // 1
    cyc(1,1,0,0,0,16'hFFFF,"R1");  // 2
    cyc(1,1,0,0,1,16'hFFFF,"R1");  // 3
    check("R1", 16'h0003);

    // controller load, cs low, linear from 1
    cyc(0,1,0,1,0,16'h1231,"R2");
    check("R2", 16'h1231);
    cyc(1,1,0,0,1,16'h0000,"R6"); check("R6", 16'h1232);
    cyc(1,1,0,0,1,16'h0000,"R6"); check("R6", 16'h1233);
    cyc(1,1,0,0,0,16'h0000,"R6"); check("R6", 16'h1230);
    cyc(1,1,0,0,0,16'h0000,"R8"); check("R8", 16'h1231);

    // interleaved from 1, mode toggled mid burst
    cyc(0,1,1,1,1,16'hABC5,"R7"); check("R7", 16'hABC5);
    cyc(1,1,0,0,0,16'h0000,"R9"); check("R9", 16'hABC4);
    cyc(1,1,0,0,1,16'h0000,"R7"); check("R7", 16'hABC7);
    cyc(1,1,0,0,0,16'h0000,"R9"); check("R9", 16'hABC6);

    // hold
    cyc(1,1,1,1,0,16'h7777,"R5"); check("R5", 16'hABC6);
    cyc(1,1,0,1,1,16'h7777,"R5"); check("R5", 16'hABC6);

    // processor strobe gating
    cyc(1,0,0,1,0,16'h5555,"R3"); check("R3", 16'hABC6);
    cyc(1,0,1,1,0,16'h5556,"R3"); check("R3", 16'h5556);

    // load beats advance
    cyc(0,1,0,0,1,16'h00F2,"R4"); check("R4", 16'h00F2);
    cyc(1,1,0,0,1,16'h0000,"R7"); check("R7", 16'h00F3);

    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);
    end
    for (int i = 0; i < 3000; i++) begin
      logic c_n, p_n, cs, a_n, md;
      logic [15:0] ad;
      string req;
      c_n = ($urandom_range(0, 9) != 0);
      p_n = ($urandom_range(0, 6) != 0);
      cs  = $urandom_range(0, 1) != 0;
      a_n = ($urandom_range(0, 3) == 0);
      md  = $urandom_range(0, 1) != 0;
      ad  = 16'($urandom);
      if (!c_n)               req = "R2";
      else if (!p_n)          req = "R3";
      else if (a_n)           req = "R5";
      else if (m_lin)         req = "R6";
      else                    req = "R7";
      cyc(c_n, p_n, cs, a_n, md, ad, req);
    end
    finish_run();
  end
endmodule